// File: doc/BRIEF.md
# Block-Copy Bus Slot Sequencer

This block decides, cycle by cycle, which channel of a two-dimensional block-copy engine uses the shared memory bus. The engine has three source read channels (A, B, C) and one destination write channel (D). A start strobe loads a channel-enable set, a fill-mode bit and a word count. The sequencer then issues a fixed pattern of slots. Each slot names the channel that owns it, or marks the slot as idle so the processor may use it.

The destination write trails the source reads by one word, because the data passes through a one-word pipeline register. As a result, every transfer begins with two idle slots. Each word forms one group of slots, and the write of word k-1 shares a group with the reads of word k. When D is enabled, a closing group carries the final write after the last read.

Within a group, the A position is always present and becomes idle when A is disabled. Fill mode inserts one extra idle slot per group. The sequencer advances only on cycles where the grant input says no higher-priority traffic holds the bus. It pulses `done` once after the last slot.

Top module: `blit_slot_seq`

## Requirements
- R1: After reset the block is idle: `busy` and `done` are low, `slot_owner` is 0, and `cpu_free` equals `grant`.
- R2: After a start is accepted, the first two granted cycles are idle slots (owner 0). The first word group begins only after them.
- R3: Owner codes are 0 for idle, 1 for A, 2 for B, 3 for C and 4 for D. Within a group, slot positions come in this order: the A position, then B if enabled, then C if enabled, then one fill idle slot if fill mode is set, then the D position if D is enabled.
- R4: The A position carries owner 1 when A is enabled and owner 0 when A is disabled.
- R5: The D position in the first group is idle, because the pipeline is still empty. In group k (k ≥ 1) it is owned by D, writing word k-1.
- R6: When D is enabled, one closing group follows the N source groups. It contains the A position (always idle), the fill idle slot if fill mode is set, and a D slot. B and C are omitted from it.
- R7: When D is disabled, the sequence ends after group N-1, with no closing group.
- R8: Fill mode adds exactly one idle slot to every group. With only D enabled and fill mode set, each word costs two idle slots and one D slot.
- R9: When `grant` is low, `slot_owner` is 0, `cpu_free` is low, and the sequence position does not advance.
- R10: A start strobe while `busy` is high is ignored. The enables, fill bit and count are captured at start, so changes on those inputs during a transfer have no effect.
- R11: A word count of 0 means 2^CNT_W words.
- R12: `done` is high for exactly one cycle, the cycle after the final granted slot. `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a transfer when idle |
| en_a | input | 1 | Enable source channel A |
| en_b | input | 1 | Enable source channel B |
| en_c | input | 1 | Enable source channel C |
| en_d | input | 1 | Enable destination channel D |
| fill_en | input | 1 | Fill mode: one extra idle slot per group |
| word_count | input | CNT_W | Words to transfer (0 means 2^CNT_W) |
| grant | input | 1 | Bus is available to this engine this cycle |
| slot_owner | output | 3 | Owner of the current slot (0 idle, 1 A, 2 B, 3 C, 4 D) |
| cpu_free | output | 1 | Current cycle may be used by the processor |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse after the final slot |

## Verification
Two things can land in the same cycle: a bus stall (grant low) and a fresh start strobe that arrives while a transfer is still running. The bench drives grant from a pseudo-random sequence and, throughout every transfer, randomizes the start, enable, fill and count inputs. The stall and the ignored strobe therefore coincide many times, including during the leading idle slots and the closing group. It then judges the result by comparing the owner codes of the granted cycles, one by one, against a slot list computed arithmetically from the configuration captured at start. It also confirms that stalled cycles show no owner and no processor slot.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;

    typedef enum logic [2:0] {
        OWN_NONE = 3'd0,
        OWN_A    = 3'd1,
        OWN_B    = 3'd2,
        OWN_C    = 3'd3,
        OWN_D    = 3'd4
    } owner_e;

    // slot positions inside one word group, in issue order
    localparam int NPOS  = 5;
    localparam int POS_A = 0;
    localparam int POS_B = 1;
    localparam int POS_C = 2;
    localparam int POS_F = 3;
    localparam int POS_D = 4;

    typedef struct packed {
        logic en_a;
        logic en_b;
        logic en_c;
        logic en_d;
        logic fill;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_GRP  = 2'd2
    } phase_e;

endpackage

// File: rtl/blit_slot_pick.sv
module blit_slot_pick
    import blit_seq_pkg::*;
(
    input  chan_cfg_t  cfg,
    input  logic       closing,
    input  logic [2:0] cur_pos,
    output logic       found,
    output logic [2:0] nxt_pos
);
    logic [NPOS-1:0] present;

    always_comb begin
        present        = '0;
        present[POS_A] = 1'b1;
        present[POS_B] = cfg.en_b && !closing;
        present[POS_C] = cfg.en_c && !closing;
        present[POS_F] = cfg.fill;
        present[POS_D] = cfg.en_d;
    end

    // lowest present position strictly after cur_pos
    always_comb begin
        found   = 1'b0;
        nxt_pos = cur_pos;
        for (int p = NPOS - 1; p >= 0; p--) begin
            if ((p > int'(cur_pos)) && present[p]) begin
                found   = 1'b1;
                nxt_pos = 3'(p);
            end
        end
    end
endmodule

// File: rtl/blit_slot_decode.sv
module blit_slot_decode
    import blit_seq_pkg::*;
(
    input  chan_cfg_t  cfg,
    input  logic       closing,
    input  logic       first_grp,
    input  logic [2:0] pos,
    output owner_e     owner
);
    always_comb begin
        owner = OWN_NONE;
        case (int'(pos))
            POS_A:   owner = (cfg.en_a && !closing) ? OWN_A : OWN_NONE;
            POS_B:   owner = OWN_B;
            POS_C:   owner = OWN_C;
            POS_F:   owner = OWN_NONE;
            POS_D:   owner = first_grp ? OWN_NONE : OWN_D;
            default: owner = OWN_NONE;
        endcase
    end
endmodule

// File: rtl/blit_slot_seq.sv
module blit_slot_seq
    import blit_seq_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             en_c,
    input  logic             en_d,
    input  logic             fill_en,
    input  logic [CNT_W-1:0] word_count,
    input  logic             grant,
    output logic [2:0]       slot_owner,
    output logic             cpu_free,
    output logic             busy,
    output logic             done
);
    localparam int CW1 = CNT_W + 1;
    localparam logic [CNT_W:0] ONE_W  = CW1'(1);
    localparam logic [CNT_W:0] MAX_WC = {1'b1, {CNT_W{1'b0}}};

    typedef struct packed {
        phase_e         phase;
        logic           lead;
        logic [CNT_W:0] k;
        logic [2:0]     pos;
        chan_cfg_t      cfg;
        logic [CNT_W:0] total;
        logic           done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic       closing;
    logic       nxt_found;
    logic [2:0] nxt_pos;
    owner_e     dec_owner;

    assign closing = (st_q.k == st_q.total);

    blit_slot_pick u_pick (
        .cfg     (st_q.cfg),
        .closing (closing),
        .cur_pos (st_q.pos),
        .found   (nxt_found),
        .nxt_pos (nxt_pos)
    );

    blit_slot_decode u_dec (
        .cfg       (st_q.cfg),
        .closing   (closing),
        .first_grp (st_q.k == '0),
        .pos       (st_q.pos),
        .owner     (dec_owner)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase    = PH_LEAD;
                    st_d.lead     = 1'b0;
                    st_d.k        = '0;
                    st_d.pos      = 3'(POS_A);
                    st_d.cfg.en_a = en_a;
                    st_d.cfg.en_b = en_b;
                    st_d.cfg.en_c = en_c;
                    st_d.cfg.en_d = en_d;
                    st_d.cfg.fill = fill_en;
                    st_d.total    = (word_count == '0) ? MAX_WC : {1'b0, word_count};
                end
            end
            PH_LEAD: begin
                if (grant) begin
                    if (st_q.lead) begin
                        st_d.phase = PH_GRP;
                        st_d.pos   = 3'(POS_A);
                    end else begin
                        st_d.lead = 1'b1;
                    end
                end
            end
            PH_GRP: begin
                if (grant) begin
                    if (nxt_found) begin
                        st_d.pos = nxt_pos;
                    end else if (closing || (((st_q.k + ONE_W) == st_q.total) && !st_q.cfg.en_d)) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.k   = st_q.k + ONE_W;
                        st_d.pos = 3'(POS_A);
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = (st_q.phase != PH_IDLE);
    assign done       = st_q.done;
    assign slot_owner = (grant && (st_q.phase == PH_GRP)) ? dec_owner : OWN_NONE;
    assign cpu_free   = grant && (slot_owner == OWN_NONE);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !grant) |=> ($stable(st_q.k) && $stable(st_q.pos) &&
                              $stable(st_q.lead) && $stable(st_q.phase)));

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(st_q.cfg) && $stable(st_q.total))));

    // R5
    no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_owner == OWN_D) |-> (st_q.k != '0));

    // R6
    word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.k <= st_q.total));

endmodule

// File: tb/blit_slot_seq_tb.sv
module blit_slot_seq_tb;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          en_a = 1'b0, en_b = 1'b0, en_c = 1'b0, en_d = 1'b0, fill_en = 1'b0;
    logic [CW-1:0] word_count = '0;
    logic          grant = 1'b0;
    logic [2:0]    slot_owner;
    logic          cpu_free, busy, done;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    blit_slot_seq #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .en_a(en_a), .en_b(en_b),
        .en_c(en_c), .en_d(en_d), .fill_en(fill_en), .word_count(word_count),
        .grant(grant), .slot_owner(slot_owner), .cpu_free(cpu_free),
        .busy(busy), .done(done)
    );

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int grp_len(bit b, bit c, bit d, bit f);
        return 1 + int'(b) + int'(c) + int'(f) + int'(d);
    endfunction

    function automatic int total_slots(bit b, bit c, bit d, bit f, int n);
        return 2 + n * grp_len(b, c, d, f) + (d ? (2 + int'(f)) : 0);
    endfunction

    // expected owner of granted slot s (0-based from start)
    function automatic int exp_owner(bit a, bit b, bit c, bit d, bit f, int n, int s);
        int glen, g, r, idx;
        bit closing;
        int lst[5];
        glen = grp_len(b, c, d, f);
        if (s < 2) return 0;
        s = s - 2;
        if (s < n * glen) begin
            g = s / glen; r = s % glen; closing = 1'b0;
        end else begin
            g = n; r = s - n * glen; closing = 1'b1;
        end
        idx = 0;
        lst[idx] = (a && !closing) ? 1 : 0; idx++;
        if (b && !closing) begin lst[idx] = 2; idx++; end
        if (c && !closing) begin lst[idx] = 3; idx++; end
        if (f)             begin lst[idx] = 0; idx++; end
        if (d)             begin lst[idx] = (g == 0) ? 0 : 4; idx++; end
        return lst[r];
    endfunction

    task automatic run_blit(bit a, bit b, bit c, bit d, bit f, int wc, bit stalls);
        int n, tot, s;
        n   = (wc == 0) ? (1 << CW) : wc;
        tot = total_slots(b, c, d, f, n);
        @(negedge clk);
        {en_a, en_b, en_c, en_d, fill_en} = {a, b, c, d, f};
        word_count = CW'(wc);
        start = 1'b1;
        grant = 1'b1;
        @(negedge clk);
        start = 1'b0;
        s = 0;
        while (s < tot) begin
            step_lfsr();
            grant = stalls ? (lfsr[1:0] != 2'b00) : 1'b1;
            // disturb captured inputs and strobe start while busy (R10)
            start = lfsr[5];
            {en_a, en_b, en_c, en_d, fill_en} = lfsr[10:6];
            word_count = lfsr[13:11];
            #1;
            if (grant) begin
                check((s < 2) ? "R2" : (d && s >= tot - 2 - int'(f)) ? "R6" : "R3",
                      int'(slot_owner), exp_owner(a, b, c, d, f, n, s));
                check("R9", int'(cpu_free), int'(slot_owner == 3'd0));
                s++;
            end else begin
                check("R9", int'({slot_owner, cpu_free}), 0);
            end
            check("R12", int'(done), 0);
            @(negedge clk);
        end
        start = 1'b0;
        grant = 1'b1;
        #1;
        check("R12", int'({done, busy}), 2);
        @(negedge clk);
        #1;
        check("R12", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1
        check("R1", int'({busy, done, slot_owner}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        grant = 1'b0;
        #1;
        check("R1", int'({busy, done, cpu_free, slot_owner}), 0);
        @(negedge clk);
        grant = 1'b1;
        #1;
        check("R1", int'(cpu_free), 1);

        // R3 R4 R5 R6 R7 R8: full sweep of configurations, counts 1..3
        for (int cfg = 0; cfg < 32; cfg++) begin
            for (int wc = 1; wc <= 3; wc++) begin
                run_blit(cfg[4], cfg[3], cfg[2], cfg[1], cfg[0], wc, 1'b0);
                run_blit(cfg[4], cfg[3], cfg[2], cfg[1], cfg[0], wc, 1'b1);
            end
        end
        // R11: every count including zero (= 8 words)
        for (int wc = 0; wc < (1 << CW); wc++) begin
            run_blit(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, wc, 1'b1);
            run_blit(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, wc, 1'b0); // R8 D-only fill
            run_blit(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, wc, 1'b1); // R7
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule